// File: doc/BRIEF.md
# RAM Signature Scanner with Privilege Filter

This block wraps a small single-port word RAM for a host bus and adds two features. The first is a privilege filter: a configuration bit limits the array to supervisor accesses. A user access while that bit is set is dropped without an acknowledge. The second is a background signature engine. When it is enabled, and the chip-level emulation input is high, it walks every RAM address in turn. It folds each word into a 32-bit multiple-input shift register and, at the end of each pass, latches the result into two 16-bit read-only registers and raises a ready flag.

The host polls the ready flag in the configuration register and then reads the high and low signature words. Reading the low word clears the flag. A stop bit models clock shutdown for low power. While it is set, the array and the engine freeze, and only the stop bit of the configuration register can be seen or changed. Register space and array space are chosen by separate select inputs that share one address bus. Every access is a single-cycle strobe, and the response is registered.

Top module: `sigscan_ram`

## Requirements
- R1: The configuration register sits at register offset 0. Its readback places the stop bit at bit 15, the ready flag at bit 10, the engine enable at bit 9 and the supervisor-only bit at bit 8. All other bits read 0, and writes to the ready flag and to the reserved bits have no effect.
- R2: After reset the configuration register reads 0x0100, and the high word (offset 4) and low word (offset 6) both read 0.
- R3: Every register access is acknowledged. Each acknowledge, together with its read data, appears in the cycle after the strobe and lasts one cycle. Accesses that are not acknowledged, and all writes, return read data 0.
- R4: With the supervisor-only bit at 1, array accesses with host_supv=0 get no acknowledge and leave the array unchanged, while supervisor accesses behave normally. With the bit at 0, both privilege levels reach the array.
- R5: While the stop bit is 1, array accesses get no acknowledge and have no effect, and the engine state, the ready flag and the latched signature stay frozen.
- R6: While the stop bit is 1, a configuration write changes only the stop bit. The configuration register reads back as 0x8000, and the signature words read 0 without clearing the ready flag.
- R7: The engine runs only while the enable bit is 1 and emu_mode is 1. In any other state the ready flag never sets, and the next run starts a fresh pass at address 0.
- R8: The signature register is seeded with 0xFFFFFFFF at the start of each pass. Each word w is folded in as s' = (s<<1) ^ (s[31] ? 0x04C11DB7 : 0) ^ {16'h0, w}, in ascending address order.
- R9: After the last address of a pass, the high word takes bits 31:16 and the low word takes bits 15:0 of the signature, the ready flag sets, and a new pass begins at once.
- R10: A read of the low word clears the ready flag and a read of the high word does not. The latched words stay unchanged until the next completed pass.
- R11: A host array access has priority over the scan read in the same cycle. The scan waits, and the signature is still that of the full RAM contents.
- R12: Writes to the signature offsets 4 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| emu_mode | input | 1 | Chip emulation mode; required for the engine to run |
| host_supv | input | 1 | 1 = supervisor access, 0 = user access |
| reg_sel | input | 1 | Selects register space (offsets 0, 4, 6 on addr[2:0]) |
| ram_sel | input | 1 | Selects the RAM array (word address on addr) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (wins if both strobes are high) |
| addr | input | AW | Word address or register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with ack |
| ack | output | 1 | Access acknowledge, one cycle after the strobe |

## Verification
Bus results are due exactly one cycle after the strobe edge. Each bench access drives its strobe on a falling edge and samples ack and rdata on the next falling edge, so the registered response is read mid-cycle. The signature needs a full pass of 64 scan cycles, plus any cycles lost to host priority. Because that latency varies, the bench does not wait a fixed count: it polls the ready bit through register reads with a bounded retry count and only then compares the two signature words against a signature it computes itself from its own copy of the RAM. Checks of the ready flag clearing and of the frozen state are made within a few cycles of the triggering access, well before a new pass could complete.

// File: rtl/sigscan_pkg.sv
package sigscan_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned SIG_W  = 32;

    localparam logic [SIG_W-1:0] SIG_POLY = 32'h04C1_1DB7;
    localparam logic [SIG_W-1:0] SIG_SEED = 32'hFFFF_FFFF;

    localparam int unsigned BIT_STOP   = 15;
    localparam int unsigned BIT_READY  = 10;
    localparam int unsigned BIT_ENABLE = 9;
    localparam int unsigned BIT_SUPV   = 8;

    localparam logic [2:0] OFF_CFG    = 3'd0;
    localparam logic [2:0] OFF_SIG_HI = 3'd4;
    localparam logic [2:0] OFF_SIG_LO = 3'd6;

    typedef struct packed {
        logic stop;
        logic enable;
        logic supv_only;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{stop: 1'b0, enable: 1'b0, supv_only: 1'b1};

    typedef enum logic [1:0] {
        RSRC_NONE = 2'd0,
        RSRC_REG  = 2'd1,
        RSRC_RAM  = 2'd2
    } rsrc_e;

    function automatic logic [SIG_W-1:0] sig_fold(input logic [SIG_W-1:0] cur,
                                                  input logic [WORD_W-1:0] w);
        logic [SIG_W-1:0] nx;
        nx = {cur[SIG_W-2:0], 1'b0};
        if (cur[SIG_W-1]) nx = nx ^ SIG_POLY;
        nx = nx ^ {{(SIG_W-WORD_W){1'b0}}, w};
        return nx;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input ctl_t c, input logic ready);
        logic [WORD_W-1:0] v;
        v = '0;
        v[BIT_STOP]   = c.stop;
        v[BIT_READY]  = ready;
        v[BIT_ENABLE] = c.enable;
        v[BIT_SUPV]   = c.supv_only;
        return v;
    endfunction

endpackage

// File: rtl/sigscan_ctl.sv
module sigscan_ctl
    import sigscan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic wr_stop,
    input  logic wr_enable,
    input  logic wr_supv,
    output ctl_t ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (cfg_wr) begin
            ctl.stop <= wr_stop;
            if (!ctl.stop) begin
                ctl.enable    <= wr_enable;
                ctl.supv_only <= wr_supv;
            end
        end
    end

    a_r2_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl == CTL_RESET));

    a_r6_stop_locks_fields: assert property (@(posedge clk) disable iff (rst)
        ctl.stop |=> ($stable(ctl.enable) && $stable(ctl.supv_only)));

endmodule

// File: rtl/sigscan_mem.sv
module sigscan_mem
    import sigscan_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [AW-1:0]     wr_addr,
    input  logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_q
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_go) rd_q <= store[rd_addr];
    end

    a_r11_single_port: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && rd_go));

endmodule

// File: rtl/sigscan_engine.sv
module sigscan_engine
    import sigscan_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  logic              enable,
    input  logic              emu_mode,
    input  logic              host_busy,
    input  logic              clr_ready,
    input  logic [WORD_W-1:0] ram_q,
    output logic              scan_rd,
    output logic [AW-1:0]     scan_addr,
    output logic              ready,
    output logic [SIG_W-1:0]  sig
);

    logic             run;
    logic             pend;
    logic             pend_last;
    logic [SIG_W-1:0] misr;
    logic [SIG_W-1:0] folded;

    assign run     = enable && emu_mode;
    assign scan_rd = run && !stop && !host_busy;
    assign folded  = sig_fold(misr, ram_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_addr <= '0;
            pend      <= 1'b0;
            pend_last <= 1'b0;
            misr      <= SIG_SEED;
            sig       <= '0;
        end else if (!stop) begin
            if (!run) begin
                scan_addr <= '0;
                pend      <= 1'b0;
                pend_last <= 1'b0;
                misr      <= SIG_SEED;
            end else begin
                pend <= scan_rd;
                if (scan_rd) begin
                    scan_addr <= scan_addr + 1'b1;
                    pend_last <= &scan_addr;
                end
                if (pend) begin
                    if (pend_last) begin
                        sig  <= folded;
                        misr <= SIG_SEED;
                    end else begin
                        misr <= folded;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               ready <= 1'b0;
        else if (!stop && run && pend && pend_last) ready <= 1'b1;
        else if (clr_ready)                    ready <= 1'b0;
    end

    a_r5_stop_freezes: assert property (@(posedge clk) disable iff (rst)
        stop |=> ($stable(ready) && $stable(sig)));

    a_r7_ready_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(run));

    a_r9_latch_at_pass_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(sig) |-> $past(pend && pend_last));

    a_r10_clear_by_low_read: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(clr_ready));

endmodule

// File: rtl/sigscan_access.sv
module sigscan_access
    import sigscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              ram_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              host_supv,
    input  logic [2:0]        off,
    input  ctl_t              ctl,
    input  logic              ready,
    input  logic [SIG_W-1:0]  sig,
    input  logic [WORD_W-1:0] ram_q,
    output logic              cfg_wr,
    output logic              clr_ready,
    output logic              ram_wr_go,
    output logic              ram_rd_go,
    output logic              ack,
    output logic [WORD_W-1:0] rdata
);

    logic              reg_hit;
    logic              reg_rd;
    logic              ram_ok;
    logic [WORD_W-1:0] reg_word;
    logic [WORD_W-1:0] reg_q;
    rsrc_e             src_q;

    assign reg_hit   = reg_sel && (rd_en || wr_en);
    assign reg_rd    = reg_sel && rd_en && !wr_en;
    assign cfg_wr    = reg_sel && wr_en && (off == OFF_CFG);
    assign clr_ready = reg_rd && (off == OFF_SIG_LO) && !ctl.stop;
    assign ram_ok    = ram_sel && !reg_sel && (rd_en || wr_en) && !ctl.stop
                       && (host_supv || !ctl.supv_only);
    assign ram_wr_go = ram_ok && wr_en;
    assign ram_rd_go = ram_ok && !wr_en;

    always_comb begin
        reg_word = '0;
        case (off)
            OFF_CFG: begin
                if (ctl.stop) reg_word[BIT_STOP] = 1'b1;
                else          reg_word = cfg_pack(ctl, ready);
            end
            OFF_SIG_HI: if (!ctl.stop) reg_word = sig[SIG_W-1:WORD_W];
            OFF_SIG_LO: if (!ctl.stop) reg_word = sig[WORD_W-1:0];
            default:    reg_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            src_q <= RSRC_NONE;
            reg_q <= '0;
        end else begin
            ack <= reg_hit || ram_ok;
            if (ram_rd_go)   src_q <= RSRC_RAM;
            else if (reg_rd) src_q <= RSRC_REG;
            else             src_q <= RSRC_NONE;
            reg_q <= reg_rd ? reg_word : '0;
        end
    end

    always_comb begin
        case (src_q)
            RSRC_RAM: rdata = ram_q;
            RSRC_REG: rdata = reg_q;
            default:  rdata = '0;
        endcase
    end

    a_r3_reg_always_acked: assert property (@(posedge clk) disable iff (rst)
        reg_hit |=> ack);

    a_r4_user_dropped: assert property (@(posedge clk) disable iff (rst)
        (ram_sel && !reg_sel && (rd_en || wr_en) && !host_supv && ctl.supv_only) |=> !ack);

    a_r5_stop_no_ram_ack: assert property (@(posedge clk) disable iff (rst)
        (ram_sel && !reg_sel && ctl.stop) |=> !ack);

    a_r3_silent_without_ack: assert property (@(posedge clk) disable iff (rst)
        !ack |-> (rdata == '0));

endmodule

// File: rtl/sigscan_ram.sv
module sigscan_ram
    import sigscan_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emu_mode,
    input  logic              host_supv,
    input  logic              reg_sel,
    input  logic              ram_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              ack
);

    ctl_t              ctl;
    logic              cfg_wr;
    logic              clr_ready;
    logic              ram_wr_go;
    logic              ram_rd_go;
    logic              scan_rd;
    logic [AW-1:0]     scan_addr;
    logic              ready;
    logic [SIG_W-1:0]  sig;
    logic [WORD_W-1:0] ram_q;
    logic              mem_rd;
    logic [AW-1:0]     mem_rd_addr;

    assign mem_rd      = ram_rd_go || scan_rd;
    assign mem_rd_addr = ram_rd_go ? addr : scan_addr;

    sigscan_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .wr_stop   (wdata[BIT_STOP]),
        .wr_enable (wdata[BIT_ENABLE]),
        .wr_supv   (wdata[BIT_SUPV]),
        .ctl       (ctl)
    );

    sigscan_access u_access (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .ram_sel   (ram_sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .host_supv (host_supv),
        .off       (addr[2:0]),
        .ctl       (ctl),
        .ready     (ready),
        .sig       (sig),
        .ram_q     (ram_q),
        .cfg_wr    (cfg_wr),
        .clr_ready (clr_ready),
        .ram_wr_go (ram_wr_go),
        .ram_rd_go (ram_rd_go),
        .ack       (ack),
        .rdata     (rdata)
    );

    sigscan_engine #(.AW(AW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .stop      (ctl.stop),
        .enable    (ctl.enable),
        .emu_mode  (emu_mode),
        .host_busy (ram_wr_go || ram_rd_go),
        .clr_ready (clr_ready),
        .ram_q     (ram_q),
        .scan_rd   (scan_rd),
        .scan_addr (scan_addr),
        .ready     (ready),
        .sig       (sig)
    );

    sigscan_mem #(.AW(AW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (ram_wr_go),
        .rd_go   (mem_rd),
        .wr_addr (addr),
        .rd_addr (mem_rd_addr),
        .wr_data (wdata),
        .rd_q    (ram_q)
    );

    a_r11_host_beats_scan: assert property (@(posedge clk) disable iff (rst)
        (ram_rd_go || ram_wr_go) |-> !scan_rd);

endmodule

// File: tb/sim_sigscan_ram.sv
module sim_sigscan_ram;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          emu_mode = 1'b0;
    logic          host_supv = 1'b0;
    logic          reg_sel = 1'b0;
    logic          ram_sel = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          ack;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [DEPTH];
    bit          got_ack;
    logic [15:0] got;
    bit          rdy;
    logic [31:0] exp_sig;

    always #(CLK_PERIOD/2) clk = ~clk;

    sigscan_ram #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .emu_mode(emu_mode), .host_supv(host_supv),
        .reg_sel(reg_sel), .ram_sel(ram_sel), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack)
    );

    function automatic logic [31:0] step_sig(input logic [31:0] s, input logic [15:0] w);
        logic [31:0] r;
        r = s << 1;
        if (s[31]) r = r ^ 32'h04C11DB7;
        return r ^ {16'h0000, w};
    endfunction

    function automatic logic [31:0] model_sig();
        logic [31:0] s;
        s = 32'hFFFFFFFF;
        for (int i = 0; i < DEPTH; i++) s = step_sig(s, model[i]);
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic bus(input bit is_reg, input bit wr, input logic [AW-1:0] a,
                       input logic [15:0] d, input bit sv,
                       output bit o_ack, output logic [15:0] o_data);
        @(negedge clk);
        reg_sel = is_reg; ram_sel = !is_reg; rd_en = !wr; wr_en = wr;
        addr = a; wdata = d; host_supv = sv;
        @(negedge clk);
        reg_sel = 0; ram_sel = 0; rd_en = 0; wr_en = 0;
        o_ack = ack; o_data = rdata;
    endtask

    task automatic poll_ready(output bit ok);
        bit a;
        logic [15:0] d;
        ok = 0;
        for (int i = 0; i < 400 && !ok; i++) begin
            bus(1, 0, 6'd0, 16'h0, 1, a, d);
            ok = d[10];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;

        // R2 reset state
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R2 cfg reset", got, 16'h0100);
        check("R3 reg ack", {31'b0, got_ack}, 1);
        @(negedge clk); check("R3 ack lasts one cycle", {31'b0, ack}, 0);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R2 hi reset", got, 0);
        bus(1, 0, 6'd6, 0, 1, got_ack, got); check("R2 lo reset", got, 0);

        // R1 reserved and ready bits not writable
        bus(1, 1, 6'd0, 16'h74FF, 1, got_ack, got); check("R3 write ack", {31'b0, got_ack}, 1);
        check("R3 write rdata zero", got, 0);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R1 reserved read zero", got, 16'h0000);
        bus(1, 1, 6'd0, 16'h0100, 1, got_ack, got);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R1 supv bit", got, 16'h0100);
        // R12 signature offsets read-only
        bus(1, 1, 6'd4, 16'hFFFF, 1, got_ack, got);
        bus(1, 1, 6'd6, 16'hFFFF, 1, got_ack, got);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R12 hi write ignored", got, 0);
        bus(1, 0, 6'd6, 0, 1, got_ack, got); check("R12 lo write ignored", got, 0);

        // fill RAM
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 16'($urandom);
            bus(0, 1, AW'(i), model[i], 1, got_ack, got);
        end
        for (int i = 0; i < DEPTH; i += 9) begin
            bus(0, 0, AW'(i), 0, 1, got_ack, got); check("R4 supv read", got, model[i]);
        end

        // R4 directed
        bus(0, 1, 6'd5, 16'hDEAD, 0, got_ack, got); check("R4 user write no ack", {31'b0, got_ack}, 0);
        bus(0, 0, 6'd5, 0, 1, got_ack, got); check("R4 user write dropped", got, model[5]);
        bus(0, 0, 6'd5, 0, 0, got_ack, got); check("R4 user read no ack", {31'b0, got_ack}, 0);
        check("R3 no-ack rdata zero", got, 0);

        // R4 random, both settings of the supervisor-only bit
        for (int ph = 0; ph < 2; ph++) begin
            bus(1, 1, 6'd0, ph == 0 ? 16'h0100 : 16'h0000, 1, got_ack, got);
            for (int n = 0; n < 120; n++) begin
                bit wr, sv, eack;
                logic [AW-1:0] a;
                logic [15:0] d;
                wr = 1'($urandom); sv = 1'($urandom); a = AW'($urandom); d = 16'($urandom);
                eack = sv || (ph == 1);
                bus(0, wr, a, d, sv, got_ack, got);
                check("R4 random ack", {31'b0, got_ack}, {31'b0, eack});
                if (eack && wr) model[a] = d;
                check("R4 random data", got, (eack && !wr) ? model[a] : 16'h0);
            end
        end

        // R7 engine idle without emulation mode
        bus(1, 1, 6'd0, 16'h0300, 1, got_ack, got);
        repeat (300) @(negedge clk);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R7 no ready without emu", got, 16'h0300);

        // R8 R9 R10 signature
        emu_mode = 1;
        exp_sig = model_sig();
        poll_ready(rdy); check("R9 ready sets", {31'b0, rdy}, 1);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R8 hi word", got, exp_sig[31:16]);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R10 hi read keeps ready", got, 16'h0700);
        bus(1, 0, 6'd6, 0, 1, got_ack, got); check("R8 lo word", got, exp_sig[15:0]);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R10 lo read clears ready", got, 16'h0300);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R10 hi held", got, exp_sig[31:16]);

        // R11 host traffic during scan
        for (int n = 0; n < 150; n++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            bus(0, 0, a, 0, 1, got_ack, got); check("R11 host read during scan", got, model[a]);
        end
        bus(1, 0, 6'd6, 0, 1, got_ack, got);
        poll_ready(rdy); check("R11 ready after traffic", {31'b0, rdy}, 1);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R11 hi word", got, exp_sig[31:16]);
        bus(1, 0, 6'd6, 0, 1, got_ack, got); check("R11 lo word", got, exp_sig[15:0]);

        // R5 R6 stop
        poll_ready(rdy);
        bus(1, 0, 6'd6, 0, 1, got_ack, got);
        bus(1, 1, 6'd0, 16'h8300, 1, got_ack, got);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R6 stop readback", got, 16'h8000);
        bus(1, 1, 6'd0, 16'h8000, 1, got_ack, got);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R6 hi reads zero in stop", got, 0);
        bus(0, 1, 6'd7, ~model[7], 1, got_ack, got); check("R5 ram write no ack", {31'b0, got_ack}, 0);
        bus(0, 0, 6'd7, 0, 1, got_ack, got); check("R5 ram read no ack", {31'b0, got_ack}, 0);
        repeat (200) @(negedge clk);
        bus(1, 1, 6'd0, 16'h0000, 1, got_ack, got);
        bus(1, 0, 6'd0, 0, 1, got_ack, got); check("R6 only stop changed", got, 16'h0300);
        check("R5 ready frozen low", {31'b0, got[10]}, 0);
        bus(0, 0, 6'd7, 0, 1, got_ack, got); check("R5 stop write dropped", got, model[7]);

        // R7 restart after disable with new contents
        bus(1, 1, 6'd0, 16'h0100, 1, got_ack, got);
        model[0] = model[0] ^ 16'h1234;
        bus(0, 1, 6'd0, model[0], 1, got_ack, got);
        bus(1, 1, 6'd0, 16'h0300, 1, got_ack, got);
        exp_sig = model_sig();
        poll_ready(rdy); check("R7 ready after restart", {31'b0, rdy}, 1);
        bus(1, 0, 6'd4, 0, 1, got_ack, got); check("R7 new hi word", got, exp_sig[31:16]);
        bus(1, 0, 6'd6, 0, 1, got_ack, got); check("R7 new lo word", got, exp_sig[15:0]);

        finish_run();
    end

endmodule